// File: doc/BRIEF.md
# Saturating wiper position controller

This block is the digital control section of a 32-tap trimmed resistor. A host selects it with an active-low select line. While the block is selected, each falling edge of an increment strobe moves a tap index one step. A direction line sets the way the step goes. The index stops at both ends and never wraps. It is decoded into a one-hot tap-select vector that drives the switch network of the resistor array.

A register stands in for nonvolatile storage. When the host deselects the block with the strobe held high, the live index is saved into that register and a store cycle of fixed length starts. When the host deselects with the strobe held low, nothing is saved. A recall strobe models power-up and loads the index back from storage. While a store cycle runs, the block is busy and ignores steps and further saves. Once it is idle and deselected, it reports standby.

All inputs are synchronous to `clk_i`. A strobe edge is seen at the first clock edge where the strobe is sampled low after it was sampled high.

Top module: `tap_trim_ctrl`

## Requirements
- R1: While `sel_ni` is high, falling edges of `step_ni` leave `tap_idx_o` unchanged.
- R2: With `sel_ni` low and not busy, each falling edge of `step_ni` changes `tap_idx_o` by one at the clock edge where the low level is first sampled: +1 when `dir_up_i` is 1, -1 when it is 0.
- R3: The index saturates: a step up at TAPS-1 (31) and a step down at 0 leave it unchanged.
- R4: `tap_sel_o` always has exactly one bit set, the bit numbered `tap_idx_o`.
- R5: A rising edge of `sel_ni` sampled with `step_ni` high saves the index into storage, and `busy_o` is then high for exactly STORE_CYC cycles, starting at the next clock edge.
- R6: A rising edge of `sel_ni` sampled with `step_ni` low leaves storage unchanged, starts no busy period and keeps the live index.
- R7: After reset, both the index and the storage hold mid-scale (TAPS/2 = 16). `recall_i` high at a clock edge loads the index from storage.
- R8: While `busy_o` is high, step edges do not move the index and a second save request is dropped.
- R9: `standby_o` is high exactly when the block is deselected (registered select high) and not busy.
- R10: A save and a recall at the same edge swap the values: the index takes the old stored value and storage takes the old index.
- R11: Direction may change between steps within one selection, and each step follows the direction level present at its own edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_ni | input | 1 | Active-low select |
| dir_up_i | input | 1 | Step direction, 1 = up |
| step_ni | input | 1 | Increment strobe, acts on falling edge |
| recall_i | input | 1 | Power-up recall of stored index |
| tap_idx_o | output | $clog2(TAPS) | Live tap index |
| tap_sel_o | output | TAPS | One-hot tap select |
| busy_o | output | 1 | Store cycle in progress |
| standby_o | output | 1 | Deselected and idle |

## Verification
Several functions can fall on the same clock edge: a save request from deselect and a recall. The bench raises `sel_ni` and `recall_i` in the same cycle, with the index and the stored value set apart beforehand. It then expects the two values to trade places. It reads the swapped index at once, and it reads the new stored value through a second recall after the busy period ends. Steps and a second save issued inside a busy period are judged the same way: the index and the recalled value must show no trace of them.

// File: rtl/trim_pkg.sv
package trim_pkg;
  parameter int unsigned DEF_TAPS      = 32;
  parameter int unsigned DEF_STORE_CYC = 500000;  // 10 ms at 50 MHz

  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;
endpackage

// File: rtl/trim_edge.sv
module trim_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_ni,
  input  logic step_ni,
  output logic step_fall_o,
  output logic sel_rise_o,
  output logic sel_q_o
);
  logic sel_q, step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b1;
      step_q <= 1'b1;
    end else begin
      sel_q  <= sel_ni;
      step_q <= step_ni;
    end
  end

  assign step_fall_o = step_q & ~step_ni;
  assign sel_rise_o  = ~sel_q & sel_ni;
  assign sel_q_o     = sel_q;
endmodule

// File: rtl/trim_counter.sv
module trim_counter #(
  parameter int unsigned TAPS = trim_pkg::DEF_TAPS,
  localparam int unsigned W   = $clog2(TAPS)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         move_i,
  input  trim_pkg::dir_e dir_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] idx_o
);
  localparam logic [W-1:0] MAX_IDX = W'(TAPS - 1);
  localparam logic [W-1:0] MID_IDX = W'(TAPS / 2);

  logic [W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (load_i) idx_d = load_val_i;
    else if (move_i) begin
      if (dir_i == trim_pkg::DIR_UP) begin
        if (idx_q != MAX_IDX) idx_d = idx_q + 1'b1;
      end else begin
        if (idx_q != '0) idx_d = idx_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= MID_IDX;
    else         idx_q <= idx_d;
  end

  assign idx_o = idx_q;

  assert_unit_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (idx_q == $past(idx_q) || idx_q == $past(idx_q) + 1'b1 ||
                 idx_q == $past(idx_q) - 1'b1));
  assert_sat_top_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q == MAX_IDX && !load_i) |=> idx_q != '0);
  assert_sat_bot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q == '0 && !load_i) |=> idx_q != MAX_IDX);
endmodule

// File: rtl/trim_store.sv
module trim_store #(
  parameter int unsigned TAPS      = trim_pkg::DEF_TAPS,
  parameter int unsigned STORE_CYC = trim_pkg::DEF_STORE_CYC,
  localparam int unsigned W        = $clog2(TAPS),
  localparam int unsigned CW       = (STORE_CYC > 1) ? $clog2(STORE_CYC) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         store_i,
  input  logic [W-1:0] idx_i,
  output logic [W-1:0] nv_o,
  output logic         busy_o
);
  localparam logic [W-1:0]  MID_IDX = W'(TAPS / 2);
  localparam logic [CW-1:0] RELOAD  = CW'(STORE_CYC - 1);

  logic [W-1:0]  nv_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nv_q   <= MID_IDX;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (store_i) begin
      nv_q   <= idx_i;
      cnt_q  <= RELOAD;
      busy_q <= 1'b1;
    end
  end

  assign nv_o   = nv_q;
  assign busy_o = busy_q;

  assert_store_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && !busy_q) |=> (busy_q && nv_q == $past(idx_i)));
  assert_busy_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(nv_q));
endmodule

// File: rtl/trim_decode.sv
module trim_decode #(
  parameter int unsigned TAPS = trim_pkg::DEF_TAPS,
  localparam int unsigned W   = $clog2(TAPS)
) (
  input  logic [W-1:0]    idx_i,
  output logic [TAPS-1:0] sel_o
);
  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign sel_o[g] = (idx_i == W'(g));
  end
endmodule

// File: rtl/tap_trim_ctrl.sv
module tap_trim_ctrl #(
  parameter int unsigned TAPS      = trim_pkg::DEF_TAPS,
  parameter int unsigned STORE_CYC = trim_pkg::DEF_STORE_CYC,
  localparam int unsigned W        = $clog2(TAPS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_ni,
  input  logic            dir_up_i,
  input  logic            step_ni,
  input  logic            recall_i,
  output logic [W-1:0]    tap_idx_o,
  output logic [TAPS-1:0] tap_sel_o,
  output logic            busy_o,
  output logic            standby_o
);
  logic step_fall, sel_rise, sel_q;
  logic busy, move_en, store_en;
  logic [W-1:0] nv;
  trim_pkg::dir_e dir;

  trim_edge u_edge (
    .clk_i, .rst_ni, .sel_ni, .step_ni,
    .step_fall_o(step_fall), .sel_rise_o(sel_rise), .sel_q_o(sel_q)
  );

  assign dir      = dir_up_i ? trim_pkg::DIR_UP : trim_pkg::DIR_DOWN;
  assign move_en  = step_fall & ~sel_ni & ~busy;
  assign store_en = sel_rise & step_ni;  // strobe high at deselect => save

  trim_counter #(.TAPS(TAPS)) u_cnt (
    .clk_i, .rst_ni, .move_i(move_en), .dir_i(dir),
    .load_i(recall_i), .load_val_i(nv), .idx_o(tap_idx_o)
  );

  trim_store #(.TAPS(TAPS), .STORE_CYC(STORE_CYC)) u_store (
    .clk_i, .rst_ni, .store_i(store_en), .idx_i(tap_idx_o),
    .nv_o(nv), .busy_o(busy)
  );

  trim_decode #(.TAPS(TAPS)) u_dec (.idx_i(tap_idx_o), .sel_o(tap_sel_o));

  assign busy_o    = busy;
  assign standby_o = sel_q & ~busy;

  assert_deselected_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_ni && !recall_i) |=> $stable(tap_idx_o));
  assert_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(tap_sel_o) == 1 && tap_sel_o[tap_idx_o]);
  assert_no_store_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_rise && !step_ni && !busy) |=> ($stable(nv) && !busy));
  assert_busy_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !recall_i) |=> $stable(tap_idx_o));
endmodule

// File: tb/tap_trim_ctrl_test.sv
module tap_trim_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS       = 32;
  localparam int STORE_CYC  = 6;
  localparam int W          = $clog2(TAPS);

  logic clk = 1'b0;
  logic rst_ni, sel_ni, dir_up_i, step_ni, recall_i;
  logic [W-1:0]    tap_idx_o;
  logic [TAPS-1:0] tap_sel_o;
  logic busy_o, standby_o;

  int n_chk = 0, n_bad = 0;
  int exp_idx;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tap_trim_ctrl #(.TAPS(TAPS), .STORE_CYC(STORE_CYC)) uut (
    .clk_i(clk), .rst_ni, .sel_ni, .dir_up_i, .step_ni, .recall_i,
    .tap_idx_o, .tap_sel_o, .busy_o, .standby_o
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_idx(input string tag);
    chk({tag, " idx"}, tap_idx_o, exp_idx);
    chk({tag, " onehot R4"}, tap_sel_o, longint'(1) << exp_idx);
  endtask

  task automatic pulse(input bit up);
    dir_up_i = up; step_ni = 1'b0; tick();
    step_ni = 1'b1; tick();
  endtask

  function automatic int sat(input int v, input bit up);
    if (up) return (v < TAPS - 1) ? v + 1 : v;
    return (v > 0) ? v - 1 : v;
  endfunction

  task automatic recall();
    recall_i = 1'b1; tick(); recall_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 50 && busy_o; i++) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    rst_ni = 1'b0; sel_ni = 1'b1; dir_up_i = 1'b0; step_ni = 1'b1; recall_i = 1'b0;
    tick(); tick(); rst_ni = 1'b1; tick();

    exp_idx = TAPS / 2;
    chk_idx("R7 reset");
    chk("R5 reset busy", busy_o, 0);
    chk("R9 reset standby", standby_o, 1);
    recall();
    chk_idx("R7 recall after reset");

    for (int i = 0; i < 3; i++) pulse(1'b1);
    chk_idx("R1 deselected steps");
    chk("R9 deselected standby", standby_o, 1);

    sel_ni = 1'b0; tick();
    chk("R9 selected standby", standby_o, 0);

    for (int i = 0; i < 20; i++) begin
      pulse(1'b1); exp_idx = sat(exp_idx, 1'b1);
      chk_idx(exp_idx == TAPS - 1 ? "R3 up sweep" : "R2 up sweep");
    end
    for (int i = 0; i < 40; i++) begin
      pulse(1'b0); exp_idx = sat(exp_idx, 1'b0);
      chk_idx(exp_idx == 0 ? "R3 down sweep" : "R2 down sweep");
    end

    lfsr = 8'h5b;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      pulse(lfsr[0]); exp_idx = sat(exp_idx, lfsr[0]);
      chk_idx("R11 mixed direction");
    end

    // deselect with strobe low: no save
    step_ni = 1'b0; sel_ni = 1'b1; tick();
    step_ni = 1'b1;
    chk("R6 no busy", busy_o, 0);
    chk("R9 standby after no-store", standby_o, 1);
    chk_idx("R6 live index kept");
    recall(); exp_idx = TAPS / 2;
    chk_idx("R6 storage unchanged");

    sel_ni = 1'b0; tick();
    for (int i = 0; i < 5; i++) pulse(1'b1);
    exp_idx = TAPS / 2 + 5;
    chk_idx("R2 before store");

    // save: edge E
    sel_ni = 1'b1; tick();
    chk("R5 busy after save", busy_o, 1);
    chk("R9 standby while busy", standby_o, 0);
    sel_ni = 1'b0; tick();                 // E+1
    pulse(1'b0);                           // E+3
    chk_idx("R8 step ignored while busy");
    sel_ni = 1'b1; tick();                 // E+4, second save request
    chk("R8 busy held", busy_o, 1);
    tick();                                // E+5
    chk("R5 busy last cycle", busy_o, 1);
    tick();                                // E+6
    chk("R5 busy ends", busy_o, 0);
    chk("R9 standby after store", standby_o, 1);

    sel_ni = 1'b0; tick();
    for (int i = 0; i < 3; i++) pulse(1'b0);
    exp_idx -= 3;
    chk_idx("R2 after store");
    step_ni = 1'b0; sel_ni = 1'b1; tick(); step_ni = 1'b1;
    recall(); exp_idx = TAPS / 2 + 5;
    chk_idx("R5 stored value recalled");

    // save and recall on the same edge
    sel_ni = 1'b0; tick();
    for (int i = 0; i < 7; i++) pulse(1'b0);
    exp_idx = TAPS / 2 - 2;
    chk_idx("R2 before swap");
    sel_ni = 1'b1; recall_i = 1'b1; tick(); recall_i = 1'b0;
    exp_idx = TAPS / 2 + 5;
    chk_idx("R10 index took stored value");
    chk("R10 busy on swap", busy_o, 1);
    wait_idle();
    chk("R10 busy cleared", busy_o, 0);
    recall(); exp_idx = TAPS / 2 - 2;
    chk_idx("R10 storage took old index");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule